// File: doc/BRIEF.md
# Programmable-Duty I2C Master Clock Generator

This block produces the SCL waveform for an I2C master from the system clock. Two count inputs set the two halves of each bit independently. The low count sets how long the block pulls SCL down. The high count sets how long it then leaves the line released. Choosing the two counts therefore fixes both the bit rate and the duty cycle. The drive output is an open-drain enable: when it is 1 the pad pulls SCL low, and when it is 0 the line floats high through the pull-up.

The block watches the synchronized SCL level while the line is released. It does not start counting the high half until it sees the line high, so a slave that stretches the clock, or another master that holds SCL low, lengthens the bit. If the line is pulled low part way through a counted high half, the block gives up the rest of that half and begins its own low half at once. This is how several masters share one clock. Two one-cycle strobes tell the byte engine when to act. One comes in the middle of the low half, where SDA may change. The other comes on the first cycle SCL is seen high, where SDA is sampled.

Top module: `scl_timing_gen`

## Requirements
- R1: With a low count L of at least 4, each low half keeps `scl_drive_low` at 1 for exactly L+1 system clock cycles.
- R2: With a high count H of at least 2 and no other device holding the line, each high half keeps `scl_drive_low` at 0 for exactly H+1 cycles.
- R3: On a free bus the bit period is L+H+2 cycles, using the clamped values of L and H.
- R4: A low count below 4 behaves as 4, and a high count below 2 behaves as 2.
- R5: After releasing SCL, the block counts no high cycles while `scl_in` is 0. Once `scl_in` goes to 1 it keeps the line released for H+1 more cycles in which `scl_in` is 1, counting from the first of them.
- R6: `sda_change_stb` is 1 for exactly one cycle in each low half. That cycle is at offset floor(Leff/2), where offset 0 is the first low cycle and Leff is the clamped low count.
- R7: `sda_sample_stb` is 1 for exactly one cycle per high half: the first released cycle in which `scl_in` is 1. It is never 1 while the block drives SCL low.
- R8: If `scl_in` is 0 while the high half is already counting (after its first high cycle), the block drives SCL low in the next cycle and starts a full low half.
- R9: While `en` is 0, SCL is released and neither strobe fires. After `en` returns to 1, the block begins with a full low half one cycle later.
- R10: During reset (`rst` = 1), SCL is released and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; 0 releases SCL and rewinds to the start of a low half |
| lo_cnt | input | CNT_W | Low half length minus one, in system clocks |
| hi_cnt | input | CNT_W | High half length minus one, in system clocks |
| scl_in | input | 1 | Synchronized level of the SCL wire |
| scl_drive_low | output | 1 | 1 = pull SCL low (open-drain enable) |
| sda_change_stb | output | 1 | One-cycle pulse in the middle of the low half |
| sda_sample_stb | output | 1 | One-cycle pulse on the first observed-high cycle |

## Verification
The bench keeps the default `CNT_W` of 8. It sweeps every low count from 0 to 11 against every high count from 0 to 9, so both clamp floors, the first unclamped values above them, and odd and even low lengths (which move the midpoint strobe) are all covered. Its wired-AND bus model, `scl_in` = not(drive) and not(external hold), lets it stretch a high half from outside and cut one short, which exercises the wait-for-high and synchronization paths.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Smallest counts the generator accepts; smaller programmed values are raised.
    localparam int MIN_HIGH_COUNT = 2;
    localparam int MIN_LOW_COUNT  = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

endpackage

// File: rtl/scl_count_clamp.sv
module scl_count_clamp #(
    parameter int CNT_W = 8,
    parameter int FLOOR = 2
) (
    input  logic [CNT_W-1:0] raw,
    output logic [CNT_W-1:0] lim
);
    localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(FLOOR);

    always_comb begin
        lim = (raw < FLOOR_V) ? FLOOR_V : raw;
    end
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] lo_lim,
    input  logic [CNT_W-1:0] hi_lim,
    output scl_phase_e       phase,
    output logic             cnt_clr,
    output logic             cnt_inc
);
    scl_phase_e phase_d;

    always_comb begin
        phase_d = phase;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (!en) begin
            phase_d = PH_IDLE;
            cnt_clr = 1'b1;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase_d = PH_LOW;
                    cnt_clr = 1'b1;
                end
                PH_LOW: begin
                    if (cnt == lo_lim) begin
                        phase_d = PH_HIGH;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (!scl_in) begin
                        // Zero count: still waiting for the wire to rise.
                        // Non-zero: someone pulled SCL early, so resynchronize.
                        if (cnt != '0) begin
                            phase_d = PH_LOW;
                            cnt_clr = 1'b1;
                        end
                    end else if (cnt == hi_lim) begin
                        phase_d = PH_LOW;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_d;
        end
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             sda_change_stb,
    output logic             sda_sample_stb
);
    logic [CNT_W-1:0] lo_lim;
    logic [CNT_W-1:0] hi_lim;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_clr;
    logic             cnt_inc;
    scl_phase_e       phase_q;

    scl_count_clamp #(.CNT_W(CNT_W), .FLOOR(MIN_LOW_COUNT)) u_lo_clamp (
        .raw (lo_cnt),
        .lim (lo_lim)
    );

    scl_count_clamp #(.CNT_W(CNT_W), .FLOOR(MIN_HIGH_COUNT)) u_hi_clamp (
        .raw (hi_cnt),
        .lim (hi_lim)
    );

    scl_phase_counter #(.CNT_W(CNT_W)) u_counter (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .cnt (cnt_q)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .scl_in  (scl_in),
        .cnt     (cnt_q),
        .lo_lim  (lo_lim),
        .hi_lim  (hi_lim),
        .phase   (phase_q),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc)
    );

    always_comb begin
        scl_drive_low  = (phase_q == PH_LOW);
        sda_change_stb = (phase_q == PH_LOW) && (cnt_q == (lo_lim >> 1));
        sda_sample_stb = (phase_q == PH_HIGH) && (cnt_q == '0) && scl_in;
    end
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             scl_in,
    input logic             scl_drive_low,
    input logic             sda_change_stb,
    input logic             sda_sample_stb,
    input scl_phase_e       phase_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] lo_lim
);
    logic [CNT_W:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || !scl_drive_low) begin
            low_run <= '0;
        end else begin
            low_run <= low_run + 1'b1;
        end
    end

    // R1: a low half never outlasts its clamped length
    a_r1_low_bounded: assert property (@(posedge clk) disable iff (rst)
        scl_drive_low |-> (low_run <= {1'b0, lo_lim}));

    // R5: waiting for the wire keeps SCL released
    a_r5_wait_released: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH && cnt_q == '0 && !scl_in) ##1 en |-> !scl_drive_low);

    // R6: change strobe only inside a low half
    a_r6_change_in_low: assert property (@(posedge clk) disable iff (rst)
        sda_change_stb |-> scl_drive_low);

    // R7: sample strobe only while released and line high
    a_r7_sample_released: assert property (@(posedge clk) disable iff (rst)
        sda_sample_stb |-> (!scl_drive_low && scl_in));

    // R8: early low during counting forces our low half next cycle
    a_r8_resync: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH && cnt_q != '0 && !scl_in) ##1 en |-> scl_drive_low);

    // R9: disabled means released and quiet on the following cycle
    a_r9_disable_release: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_drive_low && !sda_change_stb && !sda_sample_stb));
endmodule

bind scl_timing_gen scl_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .en             (en),
    .scl_in         (scl_in),
    .scl_drive_low  (scl_drive_low),
    .sda_change_stb (sda_change_stb),
    .sda_sample_stb (sda_sample_stb),
    .phase_q        (phase_q),
    .cnt_q          (cnt_q),
    .lo_lim         (lo_lim)
);

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/100ps
module tb_scl_timing_gen;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [CNT_W-1:0] lo_cnt = '0;
    logic [CNT_W-1:0] hi_cnt = '0;
    logic             ext_hold = 1'b0;
    logic             scl_in;
    logic             scl_drive_low;
    logic             sda_change_stb;
    logic             sda_sample_stb;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    // wired-AND bus: our pull-down or an external device can hold SCL low
    assign scl_in = !scl_drive_low && !ext_hold;

    scl_timing_gen #(.CNT_W(CNT_W)) dut (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .lo_cnt         (lo_cnt),
        .hi_cnt         (hi_cnt),
        .scl_in         (scl_in),
        .scl_drive_low  (scl_drive_low),
        .sda_change_stb (sda_change_stb),
        .sda_sample_stb (sda_sample_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int v, input int floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

    // called at a negedge with drive low; returns at first negedge released
    task automatic run_low(output int len, output int pos, output int n);
        len = 0; pos = -1; n = 0;
        while (scl_drive_low && len < 1000) begin
            if (sda_change_stb) begin n++; pos = len; end
            if (sda_sample_stb) n += 100;
            len++;
            @(negedge clk);
        end
    endtask

    // called at a negedge with line released; returns at first negedge driven
    task automatic run_high(output int len, output int pos, output int n);
        len = 0; pos = -1; n = 0;
        while (!scl_drive_low && len < 1000) begin
            if (sda_sample_stb) begin n++; pos = len; end
            if (sda_change_stb) n += 100;
            len++;
            @(negedge clk);
        end
    endtask

    task automatic restart(input int lo, input int hi);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        lo_cnt = CNT_W'(lo);
        hi_cnt = CNT_W'(hi);
        en = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ll, lp, ln, hl, hp, hn, le, he;

        // R10: reset holds the line released even with enable high
        repeat (2) @(negedge clk);
        en = 1'b1;
        repeat (3) @(negedge clk);
        check(!scl_drive_low && !sda_change_stb && !sda_sample_stb, "R10",
              int'({scl_drive_low, sda_change_stb, sda_sample_stb}), 0);
        rst = 1'b0;
        en = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R4 R6 R7: sweep of counts on a free bus
        for (int lo = 0; lo < 12; lo++) begin
            for (int hi = 0; hi < 10; hi++) begin
                le = eff(lo, 4);
                he = eff(hi, 2);
                restart(lo, hi);
                check(scl_drive_low, "R9 start low", int'(scl_drive_low), 1);
                for (int p = 0; p < 2; p++) begin
                    run_low(ll, lp, ln);
                    run_high(hl, hp, hn);
                    check(ll == le + 1, (lo < 4) ? "R4 low" : "R1", ll, le + 1);
                    check(hl == he + 1, (hi < 2) ? "R4 high" : "R2", hl, he + 1);
                    check(ll + hl == le + he + 2, "R3", ll + hl, le + he + 2);
                    check(ln == 1 && lp == le / 2, "R6", lp * 1000 + ln, (le / 2) * 1000 + 1);
                    check(hn == 1 && hp == 0, "R7", hp * 1000 + hn, 1);
                end
            end
        end

        // R5: stretched high half
        restart(4, 3);
        run_low(ll, lp, ln);
        ext_hold = 1'b1;
        #1;
        check(!sda_sample_stb, "R5 no sample while held", int'(sda_sample_stb), 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!scl_drive_low && !sda_sample_stb, "R5 held",
                  int'({scl_drive_low, sda_sample_stb}), 0);
        end
        ext_hold = 1'b0;
        #1;
        check(sda_sample_stb, "R7 sample on rise", int'(sda_sample_stb), 1);
        hl = 1;
        @(negedge clk);
        while (!scl_drive_low && hl < 1000) begin
            hl++;
            @(negedge clk);
        end
        check(hl == 4, "R5 count after rise", hl, 4);

        // R8: external master cuts the high half short
        restart(5, 8);
        run_low(ll, lp, ln);
        @(negedge clk);
        ext_hold = 1'b1;
        @(negedge clk);
        check(scl_drive_low, "R8 resync", int'(scl_drive_low), 1);
        ext_hold = 1'b0;
        run_low(ll, lp, ln);
        check(ll == 6, "R8 full low after resync", ll, 6);

        // R9: disable in the middle of a low half
        restart(6, 3);
        repeat (3) @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!scl_drive_low && !sda_change_stb && !sda_sample_stb, "R9 released",
                  int'({scl_drive_low, sda_change_stb, sda_sample_stb}), 0);
        end
        en = 1'b1;
        @(negedge clk);
        check(scl_drive_low, "R9 restart", int'(scl_drive_low), 1);
        run_low(ll, lp, ln);
        check(ll == 7 && lp == 3, "R9 full low", ll * 100 + lp, 703);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule